// File: doc/BRIEF.md
# Bus Event Breakpoint and Sync Pulse Unit

This unit watches every transaction on an 8-bit CPU bus with a 16-bit address and tests it against one programmed event description. The event is made of three criteria. The first is an exact address value. The second is a data value checked under a per-bit mask. The third is a set of armed transaction kinds: memory read, memory write, port read and port write. Either of the first two criteria can be switched off, and a switched-off criterion always passes.

When a transaction meets every enabled criterion, the unit takes one of two actions, chosen by a mode input. In break mode it raises a halt request. That request stays high until the host clears it, and the same signal also freezes the trace buffer. In pulse mode it sends out a short sync pulse for external test equipment, and the program keeps running. A manual break input raises the halt request at any time, whether or not a compare has matched.

A transaction is judged when its strobe is released. The values judged are the ones present in the last clock cycle in which the strobe was high, so read data and write data are both settled by then.

Top module: `bus_event_trap`

## Requirements
- R1: When address compare is enabled, a match needs all 16 address bits to equal the compare value. When it is disabled, the address has no effect on the match.
- R2: When data compare is enabled, only the data bits whose mask bit is 1 must equal the compare value. A mask of all zeros passes any data. When data compare is disabled, the data has no effect on the match.
- R3: The transaction kind code on `bus_kind` is 0 for memory read, 1 for memory write, 2 for port read and 3 for port write. Bit k of `kind_arm` arms kind k. A transaction of a kind that is not armed never matches.
- R4: A match needs all enabled criteria to hold on the same transaction. It is evaluated once per transaction, on the clock edge where `bus_strobe` is first sampled low after being high. It uses the address, data and kind from the last cycle in which the strobe was high.
- R5: In break mode (`pulse_mode`=0), a match sets `halt_req` from the evaluating edge onward. It stays set until `halt_clr` is sampled high without a new set in the same cycle. If a set and a clear arrive together, the set wins.
- R6: In pulse mode (`pulse_mode`=1), a match drives `sync_pulse` high for exactly 4 clock cycles, starting at the evaluating edge. It does not set `halt_req`.
- R7: A match that arrives while `sync_pulse` is high restarts the pulse, so it stays high for 4 full cycles after the new evaluating edge.
- R8: `manual_brk` sampled high sets `halt_req` on that edge, in either mode and with no bus activity.
- R9: `trace_freeze` always equals `halt_req`.
- R10: While `rst_n` is low and after reset, `halt_req`, `trace_freeze` and `sync_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_strobe | input | 1 | High while a bus transaction is in progress |
| bus_kind | input | 2 | Transaction kind code (R3) |
| bus_addr | input | 16 | Transaction address |
| bus_data | input | 8 | Transaction data |
| cmp_addr | input | 16 | Address compare value |
| cmp_addr_en | input | 1 | Enables the address criterion |
| cmp_data | input | 8 | Data compare value |
| cmp_data_mask | input | 8 | Bits of data that take part in the compare |
| cmp_data_en | input | 1 | Enables the data criterion |
| kind_arm | input | 4 | One arm bit per transaction kind |
| pulse_mode | input | 1 | 0 selects break, 1 selects sync pulse |
| manual_brk | input | 1 | Manual halt request |
| halt_clr | input | 1 | Host clear for the halt request |
| halt_req | output | 1 | Sticky halt request |
| trace_freeze | output | 1 | Freeze signal for the trace buffer |
| sync_pulse | output | 1 | Sync pulse for external equipment |

## Verification
The hardest situation to create is a second match that lands while a sync pulse is still running. It needs a complete strobe-high, strobe-low transaction to finish within the four pulse cycles. The bench starts the second transaction on the cycle right after the first evaluating edge, so the reload comes two cycles into the pulse. It then checks that the pulse stays high for the full restarted length. The case where a set and a clear arrive together is reached in a similar way: `halt_clr` is driven in the same cycle as the strobe release. The bench also changes the bus values after the strobe falls, which shows that the values judged are the last ones seen while the strobe was high.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int KIND_N = 4;
  localparam int KIND_W = $clog2(KIND_N);

  typedef enum logic [KIND_W-1:0] {
    K_MEM_RD = 2'd0,
    K_MEM_WR = 2'd1,
    K_IO_RD  = 2'd2,
    K_IO_WR  = 2'd3
  } kind_e;
endpackage

// File: rtl/bpu_capture.sv
module bpu_capture #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_i,
  input  logic [KW-1:0] kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          rel_o,
  output logic [KW-1:0] kind_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      kind_o   <= '0;
      addr_o   <= '0;
      data_o   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (strobe_i) begin
        kind_o <= kind_i;
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  // release: strobe was high last cycle and is low now
  assign rel_o = strobe_q & ~strobe_i;

  // R4: a release lasts one cycle only
  p_single_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |=> !rel_o);
endmodule

// File: rtl/bpu_match.sv
module bpu_match #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int KN = 4,
  parameter int KW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rel_i,
  input  logic [KW-1:0] kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] ref_addr_i,
  input  logic          addr_en_i,
  input  logic [DW-1:0] ref_data_i,
  input  logic [DW-1:0] mask_i,
  input  logic          data_en_i,
  input  logic [KN-1:0] arm_i,
  output logic          addr_ok_o,
  output logic          data_ok_o,
  output logic          kind_ok_o,
  output logic          hit_o
);
  function automatic logic addr_pass(logic en, logic [AW-1:0] a, logic [AW-1:0] r);
    return !en || (a == r);
  endfunction

  function automatic logic data_pass(logic en, logic [DW-1:0] d, logic [DW-1:0] r,
                                     logic [DW-1:0] m);
    return !en || (((d ^ r) & m) == '0);
  endfunction

  logic [KN-1:0] kind_sel;

  for (genvar k = 0; k < KN; k++) begin : g_kind
    assign kind_sel[k] = arm_i[k] && (kind_i == KW'(k));
  end

  assign addr_ok_o = addr_pass(addr_en_i, addr_i, ref_addr_i);
  assign data_ok_o = data_pass(data_en_i, data_i, ref_data_i, mask_i);
  assign kind_ok_o = |kind_sel;
  assign hit_o     = rel_i & addr_ok_o & data_ok_o & kind_ok_o;

  // R1: an enabled address criterion only passes on full equality
  p_addr_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && addr_en_i) |-> (addr_i == ref_addr_i));
  // R3: an unarmed kind never hits
  p_kind_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> arm_i[kind_i]);
  // R4: hits only on release
  p_hit_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> rel_i);
  // only one kind selected
  p_kind_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kind_sel));
endmodule

// File: rtl/bpu_halt.sv
module bpu_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic halt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     halt_o <= 1'b0;
    else if (set_i) halt_o <= 1'b1;
    else if (clr_i) halt_o <= 1'b0;
  end

  // R5: set reaches the output on the next cycle, even against a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> halt_o);
  // R5: held until cleared
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !clr_i) |=> halt_o);
  // R5: a lone clear drops it
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !halt_o);
endmodule

// File: rtl/bpu_pulse.sv
module bpu_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (fire_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_o = (cnt_q != '0);

  // R6, R7: every fire reloads the full length
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (cnt_q == LOAD));
  // R6: counts down one per cycle without a fire
  p_decay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !fire_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R6: idle stays idle
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_o && !fire_i) |=> !pulse_o);
endmodule

// File: rtl/bus_event_trap.sv
module bus_event_trap #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_strobe,
  input  logic [bpu_pkg::KIND_W-1:0] bus_kind,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_data,
  input  logic [ADDR_W-1:0]          cmp_addr,
  input  logic                       cmp_addr_en,
  input  logic [DATA_W-1:0]          cmp_data,
  input  logic [DATA_W-1:0]          cmp_data_mask,
  input  logic                       cmp_data_en,
  input  logic [bpu_pkg::KIND_N-1:0] kind_arm,
  input  logic                       pulse_mode,
  input  logic                       manual_brk,
  input  logic                       halt_clr,
  output logic                       halt_req,
  output logic                       trace_freeze,
  output logic                       sync_pulse
);
  localparam int KN = bpu_pkg::KIND_N;
  localparam int KW = bpu_pkg::KIND_W;

  logic              rel;
  logic [KW-1:0]     cap_kind;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              addr_ok, data_ok, kind_ok;
  logic              ev_hit, brk_hit, pls_hit, halt_set;

  bpu_capture #(.AW(ADDR_W), .DW(DATA_W), .KW(KW)) u_cap (
    .clk(clk), .rst_n(rst_n), .strobe_i(bus_strobe), .kind_i(bus_kind),
    .addr_i(bus_addr), .data_i(bus_data), .rel_o(rel),
    .kind_o(cap_kind), .addr_o(cap_addr), .data_o(cap_data)
  );

  bpu_match #(.AW(ADDR_W), .DW(DATA_W), .KN(KN), .KW(KW)) u_match (
    .clk(clk), .rst_n(rst_n), .rel_i(rel), .kind_i(cap_kind),
    .addr_i(cap_addr), .data_i(cap_data), .ref_addr_i(cmp_addr),
    .addr_en_i(cmp_addr_en), .ref_data_i(cmp_data), .mask_i(cmp_data_mask),
    .data_en_i(cmp_data_en), .arm_i(kind_arm), .addr_ok_o(addr_ok),
    .data_ok_o(data_ok), .kind_ok_o(kind_ok), .hit_o(ev_hit)
  );

  assign brk_hit  = ev_hit & ~pulse_mode;
  assign pls_hit  = ev_hit &  pulse_mode;
  assign halt_set = brk_hit | manual_brk;

  bpu_halt u_halt (
    .clk(clk), .rst_n(rst_n), .set_i(halt_set), .clr_i(halt_clr), .halt_o(halt_req)
  );

  bpu_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(pls_hit), .pulse_o(sync_pulse)
  );

  assign trace_freeze = halt_req;

  // R8: manual break always halts
  p_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    manual_brk |=> halt_req);
  // R6: a pulse-mode hit alone never raises the halt request
  p_pulse_no_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pls_hit && !manual_brk && !halt_req) |=> !halt_req);
  // R6: a pulse-mode hit always starts the sync pulse
  p_pulse_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pls_hit |=> sync_pulse);
endmodule

// File: tb/bus_event_trap_tb.sv
module bus_event_trap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic [1:0]  bus_kind = 2'd0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic [15:0] cmp_addr = '0;
  logic        cmp_addr_en = 1'b0;
  logic [7:0]  cmp_data = '0;
  logic [7:0]  cmp_data_mask = '0;
  logic        cmp_data_en = 1'b0;
  logic [3:0]  kind_arm = '0;
  logic        pulse_mode = 1'b0;
  logic        manual_brk = 1'b0;
  logic        halt_clr = 1'b0;
  logic        halt_req, trace_freeze, sync_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_event_trap u_dut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_kind(bus_kind),
    .bus_addr(bus_addr), .bus_data(bus_data), .cmp_addr(cmp_addr),
    .cmp_addr_en(cmp_addr_en), .cmp_data(cmp_data), .cmp_data_mask(cmp_data_mask),
    .cmp_data_en(cmp_data_en), .kind_arm(kind_arm), .pulse_mode(pulse_mode),
    .manual_brk(manual_brk), .halt_clr(halt_clr), .halt_req(halt_req),
    .trace_freeze(trace_freeze), .sync_pulse(sync_pulse)
  );

  typedef struct packed {
    logic        aen;
    logic [15:0] caddr;
    logic        den;
    logic [7:0]  cdata;
    logic [7:0]  cmask;
    logic [3:0]  arm;
    logic        pmode;
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h1234, 1'b0, 8'h00, 8'h00, 4'hF, 1'b0, 2'd0, 16'h1234, 8'h00, 1'b1}, // R1 equal
    '{1'b1, 16'h1234, 1'b0, 8'h00, 8'h00, 4'hF, 1'b0, 2'd0, 16'h1235, 8'h00, 1'b0}, // R1 lsb
    '{1'b1, 16'h1234, 1'b0, 8'h00, 8'h00, 4'hF, 1'b0, 2'd0, 16'h9234, 8'h00, 1'b0}, // R1 msb
    '{1'b0, 16'h1234, 1'b0, 8'h00, 8'h00, 4'hF, 1'b0, 2'd0, 16'hABCD, 8'h77, 1'b1}, // R1 off
    '{1'b0, 16'h0000, 1'b1, 8'hA5, 8'hF0, 4'hF, 1'b0, 2'd1, 16'h0001, 8'hAF, 1'b1}, // R2 masked
    '{1'b0, 16'h0000, 1'b1, 8'hA5, 8'hF0, 4'hF, 1'b0, 2'd1, 16'h0001, 8'hB5, 1'b0}, // R2 differ
    '{1'b0, 16'h0000, 1'b1, 8'hA5, 8'h00, 4'hF, 1'b0, 2'd2, 16'h0001, 8'h33, 1'b1}, // R2 empty
    '{1'b0, 16'h0000, 1'b0, 8'h00, 8'h00, 4'h2, 1'b0, 2'd1, 16'h0040, 8'h00, 1'b1}, // R3 armed
    '{1'b0, 16'h0000, 1'b0, 8'h00, 8'h00, 4'h2, 1'b0, 2'd0, 16'h0040, 8'h00, 1'b0}, // R3 unarmed
    '{1'b0, 16'h0000, 1'b0, 8'h00, 8'h00, 4'h8, 1'b1, 2'd3, 16'h0010, 8'h00, 1'b1}, // R3 port wr
    '{1'b0, 16'h0000, 1'b0, 8'h00, 8'h00, 4'h4, 1'b1, 2'd3, 16'h0010, 8'h00, 1'b0}, // R3 wrong
    '{1'b1, 16'h00FF, 1'b1, 8'h12, 8'hFF, 4'h4, 1'b1, 2'd2, 16'h00FF, 8'h12, 1'b1}, // R4 all
    '{1'b1, 16'h00FF, 1'b1, 8'h12, 8'hFF, 4'h4, 1'b1, 2'd2, 16'h00FF, 8'h13, 1'b0}, // R4 one off
    '{1'b0, 16'h0000, 1'b0, 8'h00, 8'h00, 4'h0, 1'b0, 2'd0, 16'h0000, 8'h00, 1'b0}  // R3 none
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int expv);
    chk(act == expv, req, act, expv);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One transaction: strobe high one cycle, then low with scrambled bus.
  // Returns at the negedge after the evaluating edge.
  task automatic txn(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    bus_strobe = 1'b1; bus_kind = k; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_strobe = 1'b0; bus_kind = ~k; bus_addr = ~a; bus_data = ~d;
    @(negedge clk);
  endtask

  task automatic clear_all;
    halt_clr = 1'b1;
    @(negedge clk);
    halt_clr = 1'b0;
    cyc(5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk_eq("R10 halt in reset", halt_req, 0);
    chk_eq("R10 sync in reset", sync_pulse, 0);
    rst_n = 1'b1;
    cyc(2);
    chk_eq("R10 halt after reset", halt_req, 0);
    chk_eq("R10 freeze after reset", trace_freeze, 0);
    chk_eq("R10 sync after reset", sync_pulse, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      cmp_addr_en = VECS[i].aen; cmp_addr = VECS[i].caddr;
      cmp_data_en = VECS[i].den; cmp_data = VECS[i].cdata;
      cmp_data_mask = VECS[i].cmask; kind_arm = VECS[i].arm;
      pulse_mode = VECS[i].pmode;
      @(negedge clk);
      txn(VECS[i].kind, VECS[i].addr, VECS[i].data);
      chk_eq($sformatf("R4 vec%0d halt", i), halt_req, int'(VECS[i].exp & ~VECS[i].pmode));
      chk_eq($sformatf("R4 vec%0d sync", i), sync_pulse, int'(VECS[i].exp & VECS[i].pmode));
      chk_eq($sformatf("R9 vec%0d freeze", i), trace_freeze, halt_req);
      clear_all;
      chk_eq($sformatf("R5 vec%0d cleared", i), halt_req, 0);
    end

    // R5: sticky until cleared
    cmp_addr_en = 1'b1; cmp_addr = 16'h2000; cmp_data_en = 1'b0;
    kind_arm = 4'hF; pulse_mode = 1'b0;
    @(negedge clk);
    txn(2'd1, 16'h2000, 8'h00);
    cyc(10);
    chk_eq("R5 held", halt_req, 1);
    chk_eq("R9 held freeze", trace_freeze, 1);
    halt_clr = 1'b1; @(negedge clk); halt_clr = 1'b0;
    chk_eq("R5 cleared", halt_req, 0);
    chk_eq("R9 cleared freeze", trace_freeze, 0);

    // R5: set wins over a clear in the same cycle
    bus_strobe = 1'b1; bus_kind = 2'd0; bus_addr = 16'h2000;
    @(negedge clk);
    bus_strobe = 1'b0; bus_addr = 16'h0000; halt_clr = 1'b1;
    @(negedge clk);
    halt_clr = 1'b0;
    chk_eq("R5 set beats clear", halt_req, 1);
    clear_all;

    // R6: pulse length 4, no halt
    pulse_mode = 1'b1;
    @(negedge clk);
    txn(2'd0, 16'h2000, 8'h00);
    for (int c = 0; c < 4; c++) begin
      chk_eq($sformatf("R6 pulse cycle %0d", c), sync_pulse, 1);
      chk_eq("R6 no halt", halt_req, 0);
      @(negedge clk);
    end
    chk_eq("R6 pulse ended", sync_pulse, 0);
    cyc(2);

    // R7: retrigger while active
    txn(2'd0, 16'h2000, 8'h00);
    txn(2'd0, 16'h2000, 8'h00);
    cyc(3);
    chk_eq("R7 still high after restart", sync_pulse, 1);
    @(negedge clk);
    chk_eq("R7 ends after restart", sync_pulse, 0);

    // R8: manual break in pulse mode, idle bus
    manual_brk = 1'b1; @(negedge clk); manual_brk = 1'b0;
    chk_eq("R8 manual halt", halt_req, 1);
    chk_eq("R8 no sync", sync_pulse, 0);
    chk_eq("R9 manual freeze", trace_freeze, 1);
    clear_all;

    // R2: data compare off ignores data
    pulse_mode = 1'b0; cmp_addr_en = 1'b0; cmp_data_en = 1'b0;
    cmp_data = 8'h00; cmp_data_mask = 8'hFF;
    @(negedge clk);
    txn(2'd3, 16'h0000, 8'hFF);
    chk_eq("R2 data disabled", halt_req, 1);
    clear_all;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule